// File: doc/BRIEF.md
# In-order multi-issue hazard checker

This block sits at the issue stage of a statically scheduled superscalar pipeline. Each cycle an upstream decoder offers a packet of up to `ISSUE_W` decoded instructions, held in program order in lanes 0 upward. Each lane has a valid bit, a destination register, two source registers and an execution class. The block compares every lane against two things. The first is the set of destinations still being computed in the execution units. The second is every older lane of the same packet. It then issues the longest run of hazard-free lanes that starts at lane 0.

Lanes that are not issued stay with the upstream stage. In the next cycle that stage offers them again, with the oldest of them moved down to lane 0. `iss_cnt` tells the sender how many lanes were taken. `in_ready` tells it that the whole packet was taken.

A per-register countdown scoreboard tracks results that are in flight. When a lane issues, the scoreboard loads the count for its destination register, and the count depends on the lane's class. A reader or rewriter of that register is blocked until the count reaches zero. Register 0 is never tracked and never causes a hazard.

Top module: `issue_gate`

## Requirements
- R1: After reset no register is marked busy. A packet of three independent lanes of different classes is issued whole, in the first cycle it is offered.
- R2: Lane k occupies bits [k*REG_W +: REG_W] of the register fields and bits [k*3 +: 3] of `lane_cls`. Class codes are 0 integer ALU, 1 integer multiply, 2 FP multiply, 3 FP add, 4 FP divide. Codes 5 to 7 behave as integer ALU.
- R3: `iss_mask` always forms a contiguous run starting at lane 0. An invalid lane ends the run, even if younger lanes are valid.
- R4: A lane whose nonzero source register is busy is not issued, and no younger lane is issued that cycle.
- R5: A lane whose nonzero destination register is busy is not issued.
- R6: A lane is not issued if it reads or writes a nonzero register that an older lane of the same packet writes.
- R7: Each class has one unit per cycle. A lane whose class (after the mapping in R2) equals that of an older lane in the packet is not issued.
- R8: Let a lane of class c with nonzero destination d issue in cycle t. A lane that reads or writes d can then issue no earlier than cycle t+LAT_c, and can issue in cycle t+LAT_c. The default latencies are ALU 1, integer multiply 3, FP multiply 4, FP add 3 and FP divide 12.
- R9: Register 0 as source or destination never causes a hazard, neither against in-flight work nor inside the packet.
- R10: `iss_cnt` equals the number of set bits of `iss_mask`. Nothing issues and `in_ready` is low while `in_valid` is low. `in_ready` is high exactly when `in_valid` is high and every valid lane is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A packet is offered this cycle |
| lane_vld | input | ISSUE_W | Per-lane instruction valid |
| lane_dst | input | ISSUE_W*REG_W | Per-lane destination register |
| lane_src_a | input | ISSUE_W*REG_W | Per-lane first source register |
| lane_src_b | input | ISSUE_W*REG_W | Per-lane second source register |
| lane_cls | input | ISSUE_W*3 | Per-lane execution class code |
| in_ready | output | 1 | Whole packet consumed this cycle |
| iss_mask | output | ISSUE_W | Lanes issued this cycle |
| iss_cnt | output | $clog2(ISSUE_W+1) | Number of lanes issued this cycle |

## Verification
Every output is combinational from the offered packet and the scoreboard counts, so a wrong count shows up in the cycle in which a dependent lane is offered. If a count is left behind or released too early, a dependent lane issues a cycle early, or stays blocked beyond t+LAT_c. The bench finds both by offering the dependent lane at every cycle up to the release cycle and one beyond it. An error in the packet compare or the prefix chain shows at once as a wrong `iss_cnt` for that packet. The vector table gives each such case its own packet.

// File: rtl/issue_pkg.sv
package issue_pkg;

    localparam int unsigned CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        UC_ALU  = 3'd0,
        UC_IMUL = 3'd1,
        UC_FMUL = 3'd2,
        UC_FADD = 3'd3,
        UC_FDIV = 3'd4
    } ucls_e;

    // Unused codes fold onto the integer ALU class.
    function automatic ucls_e norm_cls(logic [CLS_W-1:0] code);
        if (code > 3'd4) begin
            return UC_ALU;
        end
        return ucls_e'(code);
    endfunction

endpackage

// File: rtl/isg_scoreboard.sv
module isg_scoreboard
    import issue_pkg::*;
#(
    parameter int unsigned ISSUE_W  = 3,
    parameter int unsigned REG_W    = 5,
    parameter int unsigned LAT_ALU  = 1,
    parameter int unsigned LAT_IMUL = 3,
    parameter int unsigned LAT_FMUL = 4,
    parameter int unsigned LAT_FADD = 3,
    parameter int unsigned LAT_FDIV = 12,
    localparam int unsigned NREG    = 1 << REG_W,
    localparam int unsigned MAX_AB  = (LAT_ALU > LAT_IMUL) ? LAT_ALU : LAT_IMUL,
    localparam int unsigned MAX_CD  = (LAT_FMUL > LAT_FADD) ? LAT_FMUL : LAT_FADD,
    localparam int unsigned MAX_4   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD,
    localparam int unsigned MAX_LAT = (MAX_4 > LAT_FDIV) ? MAX_4 : LAT_FDIV,
    localparam int unsigned CW      = $clog2(MAX_LAT + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ISSUE_W-1:0]         iss_mask,
    input  logic [ISSUE_W*REG_W-1:0]   lane_dst,
    input  logic [ISSUE_W*CLS_W-1:0]   lane_cls,
    output logic [NREG-1:0]            busy
);

    // Cycles a destination stays blocked after the issue edge.
    function automatic logic [CW-1:0] hold_of(logic [CLS_W-1:0] code);
        logic [CW-1:0] h;
        unique case (norm_cls(code))
            UC_ALU:  h = CW'(LAT_ALU - 1);
            UC_IMUL: h = CW'(LAT_IMUL - 1);
            UC_FMUL: h = CW'(LAT_FMUL - 1);
            UC_FADD: h = CW'(LAT_FADD - 1);
            UC_FDIV: h = CW'(LAT_FDIV - 1);
            default: h = CW'(LAT_ALU - 1);
        endcase
        return h;
    endfunction

    assign busy[0] = 1'b0;

    for (genvar r = 1; r < NREG; r++) begin : g_reg
        logic [CW-1:0] cnt_q;
        logic [CW-1:0] cnt_d;
        logic          load;

        always_comb begin
            load  = 1'b0;
            cnt_d = (cnt_q != '0) ? (cnt_q - CW'(1)) : '0;
            for (int k = 0; k < ISSUE_W; k++) begin
                if (iss_mask[k] && (lane_dst[k*REG_W +: REG_W] == REG_W'(r))) begin
                    load  = 1'b1;
                    cnt_d = hold_of(lane_cls[k*CLS_W +: CLS_W]);
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign busy[r] = (cnt_q != '0);

        // R8
        quiet_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy[r] && !load) |=> !busy[r]);
    end

endmodule

// File: rtl/isg_hazard.sv
module isg_hazard
    import issue_pkg::*;
#(
    parameter int unsigned ISSUE_W = 3,
    parameter int unsigned REG_W   = 5,
    localparam int unsigned NREG   = 1 << REG_W
) (
    input  logic [ISSUE_W-1:0]         lane_vld,
    input  logic [ISSUE_W*REG_W-1:0]   lane_dst,
    input  logic [ISSUE_W*REG_W-1:0]   lane_src_a,
    input  logic [ISSUE_W*REG_W-1:0]   lane_src_b,
    input  logic [ISSUE_W*CLS_W-1:0]   lane_cls,
    input  logic [NREG-1:0]            busy,
    output logic [ISSUE_W-1:0]         haz
);

    for (genvar i = 0; i < ISSUE_W; i++) begin : g_lane
        logic [REG_W-1:0] d_i;
        logic [REG_W-1:0] a_i;
        logic [REG_W-1:0] b_i;
        ucls_e            c_i;
        logic             flight;
        logic             packed_dep;

        assign d_i = lane_dst[i*REG_W +: REG_W];
        assign a_i = lane_src_a[i*REG_W +: REG_W];
        assign b_i = lane_src_b[i*REG_W +: REG_W];
        assign c_i = norm_cls(lane_cls[i*CLS_W +: CLS_W]);

        // Read-after-write and write-after-write against in-flight results.
        always_comb begin
            flight = ((a_i != '0) && busy[a_i]) ||
                     ((b_i != '0) && busy[b_i]) ||
                     ((d_i != '0) && busy[d_i]);
        end

        // Same-packet dependences and unit conflicts with older lanes.
        always_comb begin
            packed_dep = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (lane_vld[j]) begin
                    if ((lane_dst[j*REG_W +: REG_W] != '0) &&
                        ((lane_dst[j*REG_W +: REG_W] == a_i) ||
                         (lane_dst[j*REG_W +: REG_W] == b_i) ||
                         (lane_dst[j*REG_W +: REG_W] == d_i))) begin
                        packed_dep = 1'b1;
                    end
                    if (norm_cls(lane_cls[j*CLS_W +: CLS_W]) == c_i) begin
                        packed_dep = 1'b1;
                    end
                end
            end
        end

        assign haz[i] = lane_vld[i] & (flight | packed_dep);
    end

endmodule

// File: rtl/isg_prefix.sv
module isg_prefix #(
    parameter int unsigned ISSUE_W = 3,
    localparam int unsigned CNT_W  = $clog2(ISSUE_W + 1)
) (
    input  logic               in_valid,
    input  logic [ISSUE_W-1:0] lane_vld,
    input  logic [ISSUE_W-1:0] haz,
    output logic [ISSUE_W-1:0] iss_mask,
    output logic [CNT_W-1:0]   iss_cnt,
    output logic               all_taken
);

    logic [ISSUE_W-1:0] ok;
    assign ok = lane_vld & ~haz;

    for (genvar i = 0; i < ISSUE_W; i++) begin : g_chain
        if (i == 0) begin : g_head
            assign iss_mask[i] = in_valid & ok[i];
        end else begin : g_tail
            assign iss_mask[i] = iss_mask[i-1] & ok[i];
        end
    end

    always_comb begin
        iss_cnt = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            iss_cnt = iss_cnt + CNT_W'(iss_mask[k]);
        end
    end

    assign all_taken = in_valid & ((lane_vld & ~iss_mask) == '0);

endmodule

// File: rtl/issue_gate.sv
module issue_gate
    import issue_pkg::*;
#(
    parameter int unsigned ISSUE_W  = 3,
    parameter int unsigned REG_W    = 5,
    parameter int unsigned LAT_ALU  = 1,
    parameter int unsigned LAT_IMUL = 3,
    parameter int unsigned LAT_FMUL = 4,
    parameter int unsigned LAT_FADD = 3,
    parameter int unsigned LAT_FDIV = 12,
    localparam int unsigned NREG    = 1 << REG_W,
    localparam int unsigned CNT_W   = $clog2(ISSUE_W + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [ISSUE_W-1:0]         lane_vld,
    input  logic [ISSUE_W*REG_W-1:0]   lane_dst,
    input  logic [ISSUE_W*REG_W-1:0]   lane_src_a,
    input  logic [ISSUE_W*REG_W-1:0]   lane_src_b,
    input  logic [ISSUE_W*3-1:0]       lane_cls,
    output logic                       in_ready,
    output logic [ISSUE_W-1:0]         iss_mask,
    output logic [CNT_W-1:0]           iss_cnt
);

    if (ISSUE_W < 1 || ISSUE_W > 8) begin : g_bad_width
        $error("issue_gate: ISSUE_W must lie in 1..8");
    end
    if (LAT_ALU < 1 || LAT_IMUL < 1 || LAT_FMUL < 1 || LAT_FADD < 1 || LAT_FDIV < 1) begin : g_bad_lat
        $error("issue_gate: every latency must be at least 1");
    end

    logic [NREG-1:0]    busy;
    logic [ISSUE_W-1:0] haz;

    isg_scoreboard #(
        .ISSUE_W  (ISSUE_W),
        .REG_W    (REG_W),
        .LAT_ALU  (LAT_ALU),
        .LAT_IMUL (LAT_IMUL),
        .LAT_FMUL (LAT_FMUL),
        .LAT_FADD (LAT_FADD),
        .LAT_FDIV (LAT_FDIV)
    ) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .iss_mask (iss_mask),
        .lane_dst (lane_dst),
        .lane_cls (lane_cls),
        .busy     (busy)
    );

    isg_hazard #(
        .ISSUE_W (ISSUE_W),
        .REG_W   (REG_W)
    ) u_hz (
        .lane_vld   (lane_vld),
        .lane_dst   (lane_dst),
        .lane_src_a (lane_src_a),
        .lane_src_b (lane_src_b),
        .lane_cls   (lane_cls),
        .busy       (busy),
        .haz        (haz)
    );

    isg_prefix #(
        .ISSUE_W (ISSUE_W)
    ) u_pf (
        .in_valid  (in_valid),
        .lane_vld  (lane_vld),
        .haz       (haz),
        .iss_mask  (iss_mask),
        .iss_cnt   (iss_cnt),
        .all_taken (in_ready)
    );

    // R3
    prefix_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_mask >> 1) & ~iss_mask) == '0);

    // R3
    valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_mask & ~lane_vld) == '0);

    // R10
    cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_cnt == CNT_W'($countones(iss_mask)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (iss_mask == '0 && !in_ready));

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_vld[0] && lane_dst[REG_W-1:0] == '0 &&
         lane_src_a[REG_W-1:0] == '0 && lane_src_b[REG_W-1:0] == '0) |-> iss_mask[0]);

endmodule

// File: tb/issue_gate_tb.sv
module issue_gate_tb;

    localparam int W  = 3;
    localparam int RW = 5;

    typedef struct packed {
        logic          v;
        logic [RW-1:0] d;
        logic [RW-1:0] a;
        logic [RW-1:0] b;
        logic [2:0]    c;
    } lane_t;

    typedef struct packed {
        lane_t      l0;
        lane_t      l1;
        lane_t      l2;
        logic [1:0] exp;
        logic [3:0] rq;
    } vec_t;

    localparam lane_t NOP = '{1'b0, 5'd0, 5'd0, 5'd0, 3'd0};

    // Each row starts from an empty scoreboard. Class codes: 0 ALU, 1 IMUL, 2 FMUL, 3 FADD, 4 FDIV.
    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        // R1 independent lanes, all distinct classes
        '{'{1'b1,5'd1,5'd2,5'd3,3'd0}, '{1'b1,5'd4,5'd5,5'd6,3'd1}, '{1'b1,5'd7,5'd8,5'd9,3'd3}, 2'd3, 4'd1},
        // R6 lane1 reads lane0 result
        '{'{1'b1,5'd1,5'd2,5'd3,3'd0}, '{1'b1,5'd4,5'd1,5'd5,3'd1}, '{1'b1,5'd7,5'd8,5'd9,3'd3}, 2'd1, 4'd6},
        // R6 lane1 rewrites lane0 destination
        '{'{1'b1,5'd1,5'd2,5'd3,3'd0}, '{1'b1,5'd1,5'd5,5'd6,3'd1}, NOP, 2'd1, 4'd6},
        // R7 two ALU lanes
        '{'{1'b1,5'd1,5'd2,5'd3,3'd0}, '{1'b1,5'd2,5'd4,5'd5,3'd0}, NOP, 2'd1, 4'd7},
        // R6 lane2 second source reads lane0 result
        '{'{1'b1,5'd1,5'd2,5'd3,3'd0}, '{1'b1,5'd2,5'd4,5'd5,3'd2}, '{1'b1,5'd3,5'd6,5'd1,3'd3}, 2'd2, 4'd6},
        // R3 hole at lane1 ends the run
        '{'{1'b1,5'd1,5'd2,5'd3,3'd0}, NOP, '{1'b1,5'd4,5'd5,5'd6,3'd1}, 2'd1, 4'd3},
        // R3 lane0 invalid, nothing issues
        '{NOP, '{1'b1,5'd4,5'd5,5'd6,3'd1}, '{1'b1,5'd7,5'd8,5'd9,3'd3}, 2'd0, 4'd3},
        // R9 register 0 everywhere
        '{'{1'b1,5'd0,5'd2,5'd3,3'd0}, '{1'b1,5'd0,5'd0,5'd0,3'd1}, '{1'b1,5'd5,5'd0,5'd0,3'd3}, 2'd3, 4'd9},
        // R2 code 6 folds onto ALU, conflicts with lane1 ALU
        '{'{1'b1,5'd1,5'd2,5'd3,3'd6}, '{1'b1,5'd4,5'd5,5'd6,3'd0}, NOP, 2'd1, 4'd2},
        // R2 FDIV, FMUL, IMUL are distinct classes
        '{'{1'b1,5'd1,5'd2,5'd3,3'd4}, '{1'b1,5'd4,5'd5,5'd6,3'd2}, '{1'b1,5'd7,5'd8,5'd9,3'd1}, 2'd3, 4'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [W-1:0]      lane_vld = '0;
    logic [W*RW-1:0]   lane_dst = '0;
    logic [W*RW-1:0]   lane_src_a = '0;
    logic [W*RW-1:0]   lane_src_b = '0;
    logic [W*3-1:0]    lane_cls = '0;
    logic              in_ready;
    logic [W-1:0]      iss_mask;
    logic [1:0]        iss_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    issue_gate u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .lane_vld   (lane_vld),
        .lane_dst   (lane_dst),
        .lane_src_a (lane_src_a),
        .lane_src_b (lane_src_b),
        .lane_cls   (lane_cls),
        .in_ready   (in_ready),
        .iss_mask   (iss_mask),
        .iss_cnt    (iss_cnt)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d, expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put_lane(int k, lane_t L);
        lane_vld[k]            = L.v;
        lane_dst[k*RW +: RW]   = L.d;
        lane_src_a[k*RW +: RW] = L.a;
        lane_src_b[k*RW +: RW] = L.b;
        lane_cls[k*3 +: 3]     = L.c;
    endtask

    task automatic offer(lane_t a, lane_t b, lane_t c);
        @(negedge clk);
        in_valid = 1'b1;
        put_lane(0, a);
        put_lane(1, b);
        put_lane(2, c);
        #1;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        put_lane(0, NOP);
        put_lane(1, NOP);
        put_lane(2, NOP);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 0, expected 1 finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10 reset state: nothing offered, nothing issued
        repeat (3) @(negedge clk);
        check("R10 cnt in reset", int'(iss_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 ready idle", int'(in_ready), 0);

        for (int i = 0; i < NV; i++) begin
            offer(TBL[i].l0, TBL[i].l1, TBL[i].l2);
            check($sformatf("R%0d row %0d cnt", TBL[i].rq, i), int'(iss_cnt), int'(TBL[i].exp));
            check($sformatf("R%0d row %0d mask", TBL[i].rq, i), int'(iss_mask),
                  int'((3'b1 << TBL[i].exp) - 3'b1));
            idle(14);
        end

        // R10 full packet held back while in_valid is low
        @(negedge clk);
        in_valid = 1'b0;
        put_lane(0, '{1'b1,5'd1,5'd2,5'd3,3'd0});
        put_lane(1, '{1'b1,5'd4,5'd5,5'd6,3'd1});
        #1;
        check("R10 no issue when invalid", int'(iss_cnt), 0);
        check("R10 no ready when invalid", int'(in_ready), 0);
        in_valid = 1'b1;
        #1;
        check("R10 ready on full take", int'(in_ready), 1);
        idle(14);
        offer('{1'b1,5'd1,5'd2,5'd3,3'd0}, '{1'b1,5'd2,5'd4,5'd5,3'd0}, NOP);
        check("R10 no ready on partial take", int'(in_ready), 0);
        idle(14);

        // R8 integer multiply latency 3
        offer('{1'b1,5'd4,5'd2,5'd3,3'd1}, NOP, NOP);
        check("R8 mul issue", int'(iss_cnt), 1);
        offer('{1'b1,5'd9,5'd4,5'd5,3'd0}, NOP, NOP);
        check("R8 mul dep t+1", int'(iss_cnt), 0);
        offer('{1'b1,5'd9,5'd4,5'd5,3'd0}, NOP, NOP);
        check("R8 mul dep t+2", int'(iss_cnt), 0);
        offer('{1'b1,5'd9,5'd4,5'd5,3'd0}, NOP, NOP);
        check("R8 mul dep t+3", int'(iss_cnt), 1);
        idle(14);

        // R8 ALU latency 1: dependent issues next cycle
        offer('{1'b1,5'd3,5'd1,5'd2,3'd0}, NOP, NOP);
        check("R8 alu issue", int'(iss_cnt), 1);
        offer('{1'b1,5'd10,5'd3,5'd0,3'd0}, NOP, NOP);
        check("R8 alu dep t+1", int'(iss_cnt), 1);
        idle(14);

        // FP divide latency 12 with in-flight checks along the way
        offer('{1'b1,5'd6,5'd1,5'd2,3'd4}, NOP, NOP);
        check("R8 div issue", int'(iss_cnt), 1);
        // R4 younger lane reads the divide result, older independent lane issues
        offer('{1'b1,5'd11,5'd12,5'd13,3'd0}, '{1'b1,5'd14,5'd15,5'd6,3'd1}, NOP);
        check("R4 source busy stops lane1", int'(iss_cnt), 1);
        // R5 rewrite of a busy destination
        offer('{1'b1,5'd6,5'd7,5'd8,3'd3}, NOP, NOP);
        check("R5 destination busy", int'(iss_cnt), 0);
        for (int n = 3; n < 12; n++) begin
            offer('{1'b1,5'd9,5'd6,5'd0,3'd0}, NOP, NOP);
            check($sformatf("R8 div dep t+%0d", n), int'(iss_cnt), 0);
        end
        offer('{1'b1,5'd9,5'd6,5'd0,3'd0}, NOP, NOP);
        check("R8 div dep t+12", int'(iss_cnt), 1);
        idle(14);

        // R9 register 0 written in flight never blocks a reader
        offer('{1'b1,5'd0,5'd1,5'd2,3'd4}, NOP, NOP);
        check("R9 div to r0 issues", int'(iss_cnt), 1);
        offer('{1'b1,5'd0,5'd0,5'd0,3'd2}, '{1'b1,5'd3,5'd0,5'd0,3'd0}, NOP);
        check("R9 r0 readers issue", int'(iss_cnt), 2);
        idle(14);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule